// File: doc/BRIEF.md
# Wake-Up Output Driver Controller

This block holds the digital control behind a high-side wake-up pin. Software sets a group of configuration levels: output request, timeout bypass, thermal shutdown bypass and input mode. It also issues two kinds of write strobe, a thermal re-enable pulse and a write-one-to-clear mask for the interrupt flags. Three digitized analog indications come in: an overcurrent comparator, a thermal-event flag and a comparator that reads the pin's voltage level. The block produces the enable for the output FET, an 8-bit status word and an interrupt request.

The driver is gated by four protections. A self-heating timeout turns it off a fixed time after it is switched on. A sticky thermal latch turns it off until software re-enables it. Input mode forces it off and makes the pin an input. In input mode, any edge on the pin raises an interrupt. A separate overcurrent filter reports a short only when the overcurrent persists for a qualified time, so short glitches do not raise it. All times are parameters counted in clock cycles.

The block has no data stream, so every pin is a plain level or a one-cycle strobe. There is no valid/ready handshake.

Top module: `wake_drv_ctrl`

## Requirements
- R1: After reset, drv_en is 0, the status word is 0 (with the pin comparator low) and irq is 0. With no protection active, drv_en follows cfg_out_req in the same cycle.
- R2: With the timeout active, drv_en goes low after cfg_out_req has been seen high on TMO_CYC consecutive clock edges. It stays low while cfg_out_req stays high, and status bit 3 is set during that time. Clearing cfg_out_req and setting it again restarts a full timeout.
- R3: With cfg_tmo_bypass high, drv_en stays high for as long as cfg_out_req stays high.
- R4: status bit 0 and irq are set on the clock edge at which oc_cmp has been high on SC_CYC consecutive edges. An overcurrent run of SC_CYC-1 edges sets nothing.
- R5: A thermal event (therm_evt high at a clock edge) sets status bit 2 and forces drv_en low from the next cycle. The latch holds until a one-cycle therm_reen pulse, which clears it at the next edge.
- R6: With cfg_therm_bypass high, thermal events do not set status bit 2 and do not change drv_en.
- R7: With cfg_in_mode high, drv_en is 0 whatever cfg_out_req holds.
- R8: status bit 7 shows pin_cmp two clock edges after it changes. In input mode, a rising or a falling pin edge sets status bit 1 and irq one edge after that. In output mode, pin edges set no flag.
- R9: Status bits 0 and 1 are sticky flags. Writing a 1 to bit 0 or bit 1 of flag_clr clears the matching flag at the next edge. irq is high exactly when at least one of the two flags is set. Bits 4 to 6 of the status word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_out_req | input | 1 | Software request to drive the pin high |
| cfg_tmo_bypass | input | 1 | Disables the self-heating timeout |
| cfg_therm_bypass | input | 1 | Disables the automatic thermal shutdown |
| cfg_in_mode | input | 1 | Makes the pin an input with edge interrupts |
| therm_reen | input | 1 | One-cycle strobe that clears the thermal latch |
| flag_clr | input | 2 | Write-one-to-clear strobes for the short (bit 0) and edge (bit 1) flags |
| oc_cmp | input | 1 | Overcurrent comparator output |
| therm_evt | input | 1 | Thermal-event flag |
| pin_cmp | input | 1 | Asynchronous pin-level comparator output |
| drv_en | output | 1 | Enable for the high-side FET |
| status | output | 8 | Bit 0 short, bit 1 edge, bit 2 thermal off, bit 3 timeout, bit 7 pin level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that pin_cmp holds low through reset, so the synchronizer does not treat its reset value as an edge. They also assume that therm_reen is never raised together with therm_evt, since that would hold the latch set. Another assumption is that the timeout bypass and input mode do not change in the middle of a monitored on-window. The stimulus drives pin_cmp low before reset is released and keeps the re-enable strobe apart from thermal pulses. Mode bits change only while cfg_out_req is low.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int STATUS_W = 8;
  localparam int ST_SHORT = 0;
  localparam int ST_EDGE  = 1;
  localparam int ST_THERM = 2;
  localparam int ST_TMO   = 3;
  localparam int ST_PIN   = 7;
  localparam int N_FLAGS  = 2;
endpackage

// File: rtl/wk_timeout.sv
module wk_timeout #(
  parameter int unsigned TMO_CYC = 26_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!req) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == CW'(TMO_CYC - 1)) expired <= 1'b1;
      else                         cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wk_short_filter.sv
module wk_short_filter #(
  parameter int unsigned SC_CYC = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc,
  output logic trip
);
  localparam int CW = $clog2(SC_CYC + 1);
  logic [CW-1:0] cnt;
  logic          done;

  assign trip = oc && !done && (cnt == CW'(SC_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!oc) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (trip) begin
      done <= 1'b1;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wk_thermal_latch.sv
module wk_thermal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic bypass,
  input  logic reen,
  output logic off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              off <= 1'b0;
    else if (evt && !bypass) off <= 1'b1;
    else if (reen)           off <= 1'b0;
  end
endmodule

// File: rtl/wk_pin_sense.sv
module wk_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level,
  output logic edge_seen
);
  logic [SYNC_STAGES-1:0] sync;
  logic                   prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      prev <= 1'b0;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], pin_async};
      prev <= sync[SYNC_STAGES-1];
    end
  end

  assign level     = sync[SYNC_STAGES-1];
  assign edge_seen = level ^ prev;
endmodule

// File: rtl/wake_drv_ctrl.sv
module wake_drv_ctrl
  import wk_pkg::*;
#(
  parameter int unsigned TMO_CYC = 26_000_000,
  parameter int unsigned SC_CYC  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_out_req,
  input  logic                cfg_tmo_bypass,
  input  logic                cfg_therm_bypass,
  input  logic                cfg_in_mode,
  input  logic                therm_reen,
  input  logic [N_FLAGS-1:0]  flag_clr,
  input  logic                oc_cmp,
  input  logic                therm_evt,
  input  logic                pin_cmp,
  output logic                drv_en,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  logic tmo_expired, sc_trip, therm_off, pin_level, pin_edge;
  logic [N_FLAGS-1:0] flag_set, flag_q;

  wk_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .req(cfg_out_req), .expired(tmo_expired)
  );

  wk_short_filter #(.SC_CYC(SC_CYC)) u_sc (
    .clk(clk), .rst_n(rst_n), .oc(oc_cmp), .trip(sc_trip)
  );

  wk_thermal_latch u_therm (
    .clk(clk), .rst_n(rst_n), .evt(therm_evt), .bypass(cfg_therm_bypass),
    .reen(therm_reen), .off(therm_off)
  );

  wk_pin_sense #(.SYNC_STAGES(2)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_cmp),
    .level(pin_level), .edge_seen(pin_edge)
  );

  assign flag_set[ST_SHORT] = sc_trip;
  assign flag_set[ST_EDGE]  = pin_edge && cfg_in_mode;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[g] <= 1'b0;
      else if (flag_set[g]) flag_q[g] <= 1'b1;
      else if (flag_clr[g]) flag_q[g] <= 1'b0;
    end
  end

  assign drv_en = cfg_out_req && !cfg_in_mode && !therm_off &&
                  !(tmo_expired && !cfg_tmo_bypass);

  always_comb begin
    status           = '0;
    status[ST_SHORT] = flag_q[ST_SHORT];
    status[ST_EDGE]  = flag_q[ST_EDGE];
    status[ST_THERM] = therm_off;
    status[ST_TMO]   = tmo_expired;
    status[ST_PIN]   = pin_level;
  end

  assign irq = |flag_q;
endmodule

// File: rtl/wake_drv_ctrl_chk.sv
module wake_drv_ctrl_chk #(
  parameter int unsigned TMO_CYC = 26_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_out_req,
  input logic cfg_tmo_bypass,
  input logic cfg_in_mode,
  input logic therm_reen,
  input logic oc_cmp,
  input logic drv_en,
  input logic st_short,
  input logic st_edge,
  input logic st_therm,
  input logic irq
);
  int unsigned on_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         on_run <= 0;
    else if (drv_en && !cfg_tmo_bypass) on_run <= on_run + 1;
    else                                on_run <= 0;
  end

  // R2: with the timeout active, the driver is never on longer than the window
  p_tmo_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    on_run <= TMO_CYC);

  // R1: the driver never rises without a request
  p_drv_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> cfg_out_req);

  // R4: the short flag rises only after overcurrent was present
  p_short_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_short) |-> $past(oc_cmp));

  // R5: the thermal latch holds until a re-enable strobe
  p_therm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_therm && !therm_reen) |=> st_therm);

  // R5: the thermal latch keeps the driver off
  p_therm_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_therm |-> !drv_en);

  // R7: input mode keeps the driver off
  p_in_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in_mode |-> !drv_en);

  // R8: the edge flag rises only in input mode
  p_edge_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_edge) |-> $past(cfg_in_mode));

  // R9: an interrupt request implies a set flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_short || st_edge));
endmodule

bind wake_drv_ctrl wake_drv_ctrl_chk #(.TMO_CYC(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_out_req(cfg_out_req),
  .cfg_tmo_bypass(cfg_tmo_bypass), .cfg_in_mode(cfg_in_mode),
  .therm_reen(therm_reen), .oc_cmp(oc_cmp), .drv_en(drv_en),
  .st_short(status[0]), .st_edge(status[1]), .st_therm(status[2]), .irq(irq)
);

// File: tb/test_wake_drv_ctrl.sv
module test_wake_drv_ctrl;
  localparam int TMO = 40;
  localparam int SC  = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_out_req = 0, cfg_tmo_bypass = 0, cfg_therm_bypass = 0, cfg_in_mode = 0;
  logic therm_reen = 0, oc_cmp = 0, therm_evt = 0, pin_cmp = 0;
  logic [1:0] flag_clr = 0;
  logic drv_en, irq;
  logic [7:0] status;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wake_drv_ctrl #(.TMO_CYC(TMO), .SC_CYC(SC)) i_wake_drv_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_out_req(cfg_out_req),
    .cfg_tmo_bypass(cfg_tmo_bypass), .cfg_therm_bypass(cfg_therm_bypass),
    .cfg_in_mode(cfg_in_mode), .therm_reen(therm_reen), .flag_clr(flag_clr),
    .oc_cmp(oc_cmp), .therm_evt(therm_evt), .pin_cmp(pin_cmp),
    .drv_en(drv_en), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11; cyc(1); flag_clr = 2'b00;
  endtask

  task automatic t_reset();
    check("R1 drv_en after reset", drv_en, 0);
    check("R1 status after reset", status, 0);
    check("R1 irq after reset", irq, 0);
    cfg_out_req = 1; #1;
    check("R1 drv follows request", drv_en, 1);
    cfg_out_req = 0; #1;
    check("R1 drv drops with request", drv_en, 0);
    cyc(1);
  endtask

  task automatic t_timeout();
    cfg_out_req = 1;
    cyc(TMO - 1);
    check("R2 on before timeout", drv_en, 1);
    cyc(1);
    check("R2 off at timeout", drv_en, 0);
    check("R2 timeout status", status[3], 1);
    cyc(10);
    check("R2 timeout latched", drv_en, 0);
    cfg_out_req = 0; cyc(1);
    cfg_out_req = 1; cyc(TMO - 1);
    check("R2 restart full window", drv_en, 1);
    cyc(1);
    check("R2 off again", drv_en, 0);
    cfg_out_req = 0; cyc(1);
  endtask

  task automatic t_bypass();
    cfg_tmo_bypass = 1; cyc(1);
    cfg_out_req = 1; cyc(3 * TMO);
    check("R3 bypass keeps driver on", drv_en, 1);
    cfg_out_req = 0; cyc(1);
    cfg_tmo_bypass = 0; cyc(1);
  endtask

  task automatic t_short();
    oc_cmp = 1; cyc(SC - 1); oc_cmp = 0; cyc(2);
    check("R4 glitch rejected", status[0], 0);
    check("R4 glitch no irq", irq, 0);
    oc_cmp = 1; cyc(SC - 1);
    check("R4 not yet tripped", status[0], 0);
    cyc(1);
    check("R4 trip flag", status[0], 1);
    check("R4 trip irq", irq, 1);
    oc_cmp = 0; cyc(3);
    check("R9 flag sticky", status[0], 1);
    flag_clr = 2'b10; cyc(1); flag_clr = 0;
    check("R9 other clear bit ignored", status[0], 1);
    flag_clr = 2'b01; cyc(1); flag_clr = 0;
    check("R9 w1c clears short", status[0], 0);
    check("R9 irq drops", irq, 0);
  endtask

  task automatic t_thermal();
    cfg_tmo_bypass = 1; cyc(1);
    cfg_out_req = 1;
    therm_evt = 1; cyc(1); therm_evt = 0;
    check("R5 thermal off", drv_en, 0);
    check("R5 thermal status", status[2], 1);
    cyc(5);
    check("R5 thermal sticky", drv_en, 0);
    therm_reen = 1; cyc(1); therm_reen = 0;
    check("R5 re-enable", drv_en, 1);
    cfg_therm_bypass = 1;
    therm_evt = 1; cyc(1); therm_evt = 0; cyc(1);
    check("R6 bypass keeps driver", drv_en, 1);
    check("R6 bypass no status", status[2], 0);
    cfg_out_req = 0; cfg_therm_bypass = 0; cfg_tmo_bypass = 0; cyc(1);
  endtask

  task automatic t_input();
    pin_cmp = 1; cyc(2);
    check("R8 level mirror", status[7], 1);
    cyc(2);
    check("R8 no flag in output mode", status[1], 0);
    pin_cmp = 0; cyc(4);
    check("R8 mirror low", status[7], 0);
    check("R8 no flag falling output mode", irq, 0);
    cfg_in_mode = 1; cfg_out_req = 1; #1;
    check("R7 input mode forces off", drv_en, 0);
    cyc(1);
    pin_cmp = 1; cyc(2);
    check("R8 edge flag not before latency", status[1], 0);
    cyc(1);
    check("R8 rising edge flag", status[1], 1);
    check("R8 rising edge irq", irq, 1);
    clr_flags();
    check("R9 edge flag cleared", status[1], 0);
    pin_cmp = 0; cyc(3);
    check("R8 falling edge flag", status[1], 1);
    check("R7 still off", drv_en, 0);
    clr_flags();
    cfg_out_req = 0; cfg_in_mode = 0; cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_timeout();
    t_bypass();
    t_short();
    t_thermal();
    t_input();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule